// File: doc/BRIEF.md
# Dual TLB Address Translation and Access Check Unit

This block turns a 32-bit virtual address into a physical address by searching two fully associative translation buffers: a 4-entry buffer used only by instruction fetches and a 64-entry buffer shared by all accesses. Each entry has its own page size, an address-space identifier, a shared flag, a 2-bit protection field and a dirty flag. Once an entry matches, the block checks the access type (fetch, load or store) and the privilege mode against the entry. It then returns either a physical address or one exception code.

Software fills the shared buffer through a direct write port. The block fills the fetch buffer by itself: when a fetch misses the small buffer but hits the large one, the matching entry is copied into a fetch-buffer slot. The block also keeps the replacement counter for the shared buffer, which software reads to choose where its next entry goes. Each result is registered and appears one cycle after the request. When more than one entry matches, the block raises an error flag and returns no translation.

Top module: `dual_tlb_mmu`

## Requirements
- R1: An entry matches only if its valid flag is set and the address bits above the page offset equal the entry's page number under the same mask. The size code selects the page: 0 is 1 KB, 1 is 4 KB, 2 is 64 KB and 3 is 1 MB.
- R2: A non-shared entry also needs its identifier to equal `req_asid`. That comparison is dropped when `single_virt` and `req_priv` are both 1. Shared entries ignore the identifier.
- R3: On a successful translation, `rsp_paddr` keeps the request address bits below the page size. The bits above it come from the entry frame `{3'b000, ppn, 10'b0}`, so bits 31:29 are always zero.
- R4: `rsp_valid` is 1 exactly in the cycle after a cycle with `req_valid` high, and that cycle carries the result of that request. After reset, and after a cycle with no request, every response output is 0.
- R5: Exception codes are 0 none, 1 fetch/load miss, 2 store miss, 3 fetch/load protection, 4 store protection and 5 first write to a clean page. When no entry matches, a store gets 2 and anything else gets 1. `rsp_paddr` is 0 whenever the code is not 0.
- R6: Access kinds are 0 fetch, 1 load and 2 store. A privileged fetch is always allowed. A user fetch needs protection bit 1 set, or it gets code 3.
- R7: For a privileged load or store, protection values 0 and 2 are read-only, so a store gets code 4. Values 1 and 3 allow stores, but a store to an entry with a clear dirty flag gets code 5.
- R8: For a user load or store, protection values 0 and 1 always give code 3 (load) or 4 (store). Value 2 allows only loads, so a store gets code 4. Value 3 allows both, and a store to a clean page gets code 5.
- R9: A fetch searches the fetch buffer first, and `rsp_itlb_hit` is 1 when the fetch buffer supplied the translation. If the fetch buffer has no match and exactly one shared entry matches, that entry is copied into the fetch buffer and used by later fetches. Later writes to the shared buffer do not change the copy.
- R10: The refill slot is the lowest-numbered invalid fetch-buffer slot. If all slots are valid, the slot is the state of a 2-bit shift register. That register resets to 1, steps 1, 3, 2, 1 on every refill, and applies next state {s[0], s[1]^s[0]}.
- R11: `urc_value` resets to 0 and advances by one on every request. It wraps to 0 when the next value would equal 64, or would equal a nonzero `urc_bound`.
- R12: If two or more entries match in the buffer being used, `rsp_multi` is 1, the code is 0, `rsp_paddr` is 0 and no refill happens.
- R13: A write with `wr_en` high places the entry at `wr_idx`. Lookups see the new entry from the next cycle on; a lookup in the same cycle as the write still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store |
| req_priv | input | 1 | 1 = privileged mode |
| req_asid | input | 8 | Current address-space identifier |
| single_virt | input | 1 | Skip the identifier check for privileged accesses |
| urc_bound | input | 6 | Wrap boundary for the replacement counter, 0 = none |
| wr_en | input | 1 | Write a shared-buffer entry |
| wr_idx | input | 6 | Entry index to write |
| wr_vpn | input | 22 | Virtual page number (address bits 31:10) |
| wr_ppn | input | 19 | Physical frame (address bits 28:10) |
| wr_asid | input | 8 | Entry identifier |
| wr_size | input | 2 | Page size code |
| wr_prot | input | 2 | Protection field |
| wr_valid | input | 1 | Entry valid flag |
| wr_shared | input | 1 | Entry shared flag |
| wr_dirty | input | 1 | Entry dirty flag |
| rsp_valid | output | 1 | Result valid |
| rsp_paddr | output | 32 | Physical address, 0 if not translated |
| rsp_exc | output | 3 | Exception code |
| rsp_multi | output | 1 | Multiple-match error |
| rsp_itlb_hit | output | 1 | Translation came from the fetch buffer |
| urc_value | output | 6 | Replacement counter |

## Verification
The bench checks page masking at every size: an address just outside a 4 KB page must miss, while one far inside a 1 MB page must hit. A design that masks at a fixed size would translate the wrong pages. It runs the full protection and dirty matrix for both privilege modes and all three access kinds. Swapping the privileged and user tables, or reporting a protection fault where a first-write exception belongs, shows up there as a wrong code.

For the fetch buffer, the bench fills more pages than there are slots, so the shift-register order decides which copy is evicted. It then invalidates shared entries to show that fetches still hit their stale copies. A wrong tap, or a refill after a multiple match, changes which fetch reports `rsp_itlb_hit`.

Other cases cover the counter's nonzero boundary and its wrap at 64, a write and a lookup in the same cycle, and identifier matching with and without the single-virtual bit.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
  localparam int VA_W   = 32;
  localparam int ASID_W = 8;
  localparam int VPN_W  = 22;
  localparam int PPN_W  = 19;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } acc_e;

  typedef enum logic [2:0] {
    EXC_NONE     = 3'd0,
    EXC_MISS_LD  = 3'd1,
    EXC_MISS_ST  = 3'd2,
    EXC_PROT_LD  = 3'd3,
    EXC_PROT_ST  = 3'd4,
    EXC_PAGE_MOD = 3'd5
  } exc_e;

  typedef struct packed {
    logic              valid;
    logic              shared;
    logic              dirty;
    logic [1:0]        size;
    logic [1:0]        prot;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic [PPN_W-1:0]  ppn;
  } tlb_entry_t;

  // Mask of the page-number bits for a size code
  function automatic logic [VA_W-1:0] page_mask(input logic [1:0] size);
    case (size)
      2'd0:    page_mask = 32'hFFFF_FC00;
      2'd1:    page_mask = 32'hFFFF_F000;
      2'd2:    page_mask = 32'hFFFF_0000;
      default: page_mask = 32'hFFF0_0000;
    endcase
  endfunction

  function automatic logic entry_hit(input tlb_entry_t e, input logic [VA_W-1:0] va,
                                     input logic [ASID_W-1:0] asid, input logic skip_asid);
    logic [VA_W-1:0] m;
    m = page_mask(e.size);
    entry_hit = e.valid && (({e.vpn, 10'b0} & m) == (va & m)) &&
                (e.shared || skip_asid || (e.asid == asid));
  endfunction

  function automatic logic [VA_W-1:0] form_paddr(input tlb_entry_t e, input logic [VA_W-1:0] va);
    logic [VA_W-1:0] m;
    m = page_mask(e.size);
    form_paddr = (va & ~m) | ({3'b000, e.ppn, 10'b0} & m & 32'h1FFF_FFFF);
  endfunction

  // Protection and dirty decision for a matched entry
  function automatic exc_e access_verdict(input tlb_entry_t e, input acc_e acc, input logic priv);
    logic rd_ok, wr_ok;
    rd_ok = priv | e.prot[1];
    wr_ok = priv ? e.prot[0] : (e.prot == 2'b11);
    if (acc == ACC_STORE) begin
      if (!wr_ok)        access_verdict = EXC_PROT_ST;
      else if (!e.dirty) access_verdict = EXC_PAGE_MOD;
      else               access_verdict = EXC_NONE;
    end else begin
      access_verdict = rd_ok ? EXC_NONE : EXC_PROT_LD;
    end
  endfunction
endpackage

// File: rtl/tlb_array.sv
module tlb_array
  import tlbx_pkg::*;
#(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  tlb_entry_t        wr_entry,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_skip_asid,
  output logic              hit_any,
  output logic              hit_multi,
  output tlb_entry_t        hit_entry,
  output logic [N-1:0]      valid_vec
);
  tlb_entry_t   ent_q [N];
  logic [N-1:0] hit_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) ent_q[i] <= '0;
    end else if (wr_en) begin
      ent_q[wr_idx] <= wr_entry;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g]   = entry_hit(ent_q[g], lk_vaddr, lk_asid, lk_skip_asid);
    assign valid_vec[g] = ent_q[g].valid;
  end

  always_comb begin
    hit_entry = '0;
    for (int i = 0; i < N; i++)
      if (hit_vec[i]) hit_entry = tlb_entry_t'(hit_entry | ent_q[i]);
  end

  assign hit_any   = |hit_vec;
  assign hit_multi = |(hit_vec & (hit_vec - N'(1)));
endmodule

// File: rtl/itlb_victim.sv
module itlb_victim #(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     valid_vec,
  input  logic             refill,
  output logic [IDX_W-1:0] slot
);
  logic [IDX_W-1:0] lfsr_q, lfsr_nxt, free_idx;
  logic             free_any;

  if (IDX_W == 2) begin : g_lfsr2
    assign lfsr_nxt = {lfsr_q[0], lfsr_q[1] ^ lfsr_q[0]};
  end else begin : g_count
    assign lfsr_nxt = lfsr_q + IDX_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      lfsr_q <= IDX_W'(1);
    else if (refill) lfsr_q <= lfsr_nxt;
  end

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign slot = free_any ? free_idx : lfsr_q;
endmodule

// File: rtl/repl_counter.sv
module repl_counter #(
  parameter int N = 64,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] bound,
  output logic [W-1:0] count
);
  logic [W:0] inc;
  logic       wrap;

  assign inc  = {1'b0, count} + (W+1)'(1);
  assign wrap = (inc == (W+1)'(N)) || ((bound != '0) && (inc == {1'b0, bound}));

  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (step) count <= wrap ? '0 : inc[W-1:0];
  end
endmodule

// File: rtl/dual_tlb_mmu.sv
module dual_tlb_mmu
  import tlbx_pkg::*;
#(
  parameter int ITLB_N = 4,
  parameter int UTLB_N = 64,
  localparam int I_IDX = (ITLB_N > 1) ? $clog2(ITLB_N) : 1,
  localparam int U_IDX = (UTLB_N > 1) ? $clog2(UTLB_N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_kind,
  input  logic              req_priv,
  input  logic [ASID_W-1:0] req_asid,
  input  logic              single_virt,
  input  logic [U_IDX-1:0]  urc_bound,
  input  logic              wr_en,
  input  logic [U_IDX-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [PPN_W-1:0]  wr_ppn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [1:0]        wr_size,
  input  logic [1:0]        wr_prot,
  input  logic              wr_valid,
  input  logic              wr_shared,
  input  logic              wr_dirty,
  output logic              rsp_valid,
  output logic [VA_W-1:0]   rsp_paddr,
  output logic [2:0]        rsp_exc,
  output logic              rsp_multi,
  output logic              rsp_itlb_hit,
  output logic [U_IDX-1:0]  urc_value
);
  acc_e        acc;
  logic        is_fetch, is_store, skip_asid;
  tlb_entry_t  sw_entry, i_ent, u_ent, sel_ent;
  logic        i_any, i_multi, u_any, u_multi;
  logic [ITLB_N-1:0] itlb_valid;
  logic [UTLB_N-1:0] utlb_valid;
  logic        use_itlb, lookup_any, lookup_multi, refill_fire, xlate_ok;
  logic [I_IDX-1:0] victim_slot;
  exc_e        verdict, exc_d;
  logic [VA_W-1:0] paddr_d;

  assign acc       = acc_e'(req_kind);
  assign is_fetch  = (acc == ACC_FETCH);
  assign is_store  = (acc == ACC_STORE);
  assign skip_asid = single_virt & req_priv;

  assign sw_entry = '{valid: wr_valid, shared: wr_shared, dirty: wr_dirty, size: wr_size,
                      prot: wr_prot, asid: wr_asid, vpn: wr_vpn, ppn: wr_ppn};

  tlb_array #(.N(UTLB_N)) u_utlb (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_entry(sw_entry),
    .lk_vaddr(req_vaddr), .lk_asid(req_asid), .lk_skip_asid(skip_asid),
    .hit_any(u_any), .hit_multi(u_multi), .hit_entry(u_ent), .valid_vec(utlb_valid)
  );

  tlb_array #(.N(ITLB_N)) u_itlb (
    .clk(clk), .rst_n(rst_n), .wr_en(refill_fire), .wr_idx(victim_slot), .wr_entry(u_ent),
    .lk_vaddr(req_vaddr), .lk_asid(req_asid), .lk_skip_asid(skip_asid),
    .hit_any(i_any), .hit_multi(i_multi), .hit_entry(i_ent), .valid_vec(itlb_valid)
  );

  itlb_victim #(.N(ITLB_N)) u_victim (
    .clk(clk), .rst_n(rst_n), .valid_vec(itlb_valid), .refill(refill_fire), .slot(victim_slot)
  );

  repl_counter #(.N(UTLB_N)) u_urc (
    .clk(clk), .rst_n(rst_n), .step(req_valid), .bound(urc_bound), .count(urc_value)
  );

  // Fetches consult the small buffer first
  assign use_itlb     = is_fetch & i_any;
  assign sel_ent      = use_itlb ? i_ent : u_ent;
  assign lookup_any   = use_itlb | u_any;
  assign lookup_multi = use_itlb ? i_multi : u_multi;
  assign refill_fire  = req_valid & is_fetch & ~i_any & u_any & ~u_multi;

  assign verdict = access_verdict(sel_ent, acc, req_priv);

  always_comb begin
    if (lookup_multi)     exc_d = EXC_NONE;
    else if (!lookup_any) exc_d = is_store ? EXC_MISS_ST : EXC_MISS_LD;
    else                  exc_d = verdict;
  end

  assign xlate_ok = lookup_any & ~lookup_multi & (exc_d == EXC_NONE);
  assign paddr_d  = xlate_ok ? form_paddr(sel_ent, req_vaddr) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n || !req_valid) begin
      rsp_valid    <= 1'b0;
      rsp_paddr    <= '0;
      rsp_exc      <= 3'd0;
      rsp_multi    <= 1'b0;
      rsp_itlb_hit <= 1'b0;
    end else begin
      rsp_valid    <= 1'b1;
      rsp_paddr    <= paddr_d;
      rsp_exc      <= exc_d;
      rsp_multi    <= lookup_multi;
      rsp_itlb_hit <= use_itlb & ~i_multi;
    end
  end
endmodule

// File: rtl/dual_tlb_mmu_chk.sv
module dual_tlb_mmu_chk #(
  parameter int ITLB_N = 4,
  parameter int UTLB_N = 64,
  localparam int I_IDX = (ITLB_N > 1) ? $clog2(ITLB_N) : 1,
  localparam int U_IDX = (UTLB_N > 1) ? $clog2(UTLB_N) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_kind,
  input logic              req_priv,
  input logic [U_IDX-1:0]  urc_bound,
  input logic              wr_en,
  input logic [U_IDX-1:0]  wr_idx,
  input logic              wr_valid,
  input logic              rsp_valid,
  input logic [31:0]       rsp_paddr,
  input logic [2:0]        rsp_exc,
  input logic              rsp_multi,
  input logic              rsp_itlb_hit,
  input logic [U_IDX-1:0]  urc_value,
  input logic              refill_fire,
  input logic [I_IDX-1:0]  victim_slot,
  input logic [ITLB_N-1:0] itlb_valid,
  input logic [UTLB_N-1:0] utlb_valid
);
  assert_rsp_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_rsp_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && rsp_exc == 3'd0 && rsp_paddr == 32'd0));
  assert_exc_no_paddr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_exc != 3'd0) |-> (rsp_paddr == 32'd0));
  assert_store_codes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind != 2'd2) |=> (rsp_exc != 3'd2 && rsp_exc != 3'd4 && rsp_exc != 3'd5));
  assert_priv_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd0 && req_priv) |=> (rsp_exc != 3'd3));
  assert_itlb_fetch_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind != 2'd0) |=> !rsp_itlb_hit);
  assert_refill_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
    refill_fire |=> itlb_valid[$past(victim_slot)]);
  assert_refill_free_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_fire && !(&itlb_valid)) |-> !itlb_valid[victim_slot]);
  assert_urc_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(urc_value));
  assert_urc_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && urc_bound != '0 && ({1'b0, urc_value} + 1'b1) == {1'b0, urc_bound})
      |=> (urc_value == '0));
  assert_multi_empty_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_multi |-> (rsp_exc == 3'd0 && rsp_paddr == 32'd0 && !rsp_itlb_hit));
  assert_write_lands_R13: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (utlb_valid[$past(wr_idx)] == $past(wr_valid)));
endmodule

bind dual_tlb_mmu dual_tlb_mmu_chk #(.ITLB_N(ITLB_N), .UTLB_N(UTLB_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind), .req_priv(req_priv),
  .urc_bound(urc_bound), .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
  .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_exc(rsp_exc), .rsp_multi(rsp_multi),
  .rsp_itlb_hit(rsp_itlb_hit), .urc_value(urc_value), .refill_fire(refill_fire),
  .victim_slot(victim_slot), .itlb_valid(itlb_valid), .utlb_valid(utlb_valid)
);

// File: tb/tb_dual_tlb_mmu.sv
module tb_dual_tlb_mmu;
  logic        clk, rst_n;
  logic        req_valid, req_priv, single_virt;
  logic [31:0] req_vaddr;
  logic [1:0]  req_kind;
  logic [7:0]  req_asid;
  logic [5:0]  urc_bound;
  logic        wr_en, wr_valid, wr_shared, wr_dirty;
  logic [5:0]  wr_idx;
  logic [21:0] wr_vpn;
  logic [18:0] wr_ppn;
  logic [7:0]  wr_asid;
  logic [1:0]  wr_size, wr_prot;
  logic        rsp_valid, rsp_multi, rsp_itlb_hit;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_exc;
  logic [5:0]  urc_value;

  dual_tlb_mmu dut (.*);

  typedef struct {
    bit v, sh, d; bit [1:0] sz, pr; bit [7:0] asid; bit [21:0] vpn; bit [18:0] ppn;
  } ment_t;

  ment_t um [64];
  ment_t im [4];
  bit [1:0] lf;
  int urc_m;
  int vectors = 0, fails = 0;

  initial begin clk = 0; forever #10 clk = ~clk; end

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  function automatic int shamt(bit [1:0] sz);
    case (sz) 2'd0: return 10; 2'd1: return 12; 2'd2: return 16; default: return 20; endcase
  endfunction

  function automatic bit m_hit(ment_t e, bit [31:0] va, bit [7:0] asid, bit skip);
    int s = shamt(e.sz);
    bit [31:0] tag = {e.vpn, 10'b0};
    return e.v && ((tag >> s) == (va >> s)) && (e.sh || skip || e.asid == asid);
  endfunction

  function automatic ment_t mk(bit [21:0] vpn, bit [18:0] ppn, bit [7:0] asid, bit [1:0] sz,
                               bit [1:0] pr, bit v, bit sh, bit d);
    ment_t e;
    e.vpn = vpn; e.ppn = ppn; e.asid = asid; e.sz = sz; e.pr = pr; e.v = v; e.sh = sh; e.d = d;
    return e;
  endfunction

  function automatic ment_t rnd_ent();
    return mk(22'($urandom), 19'($urandom), 8'($urandom_range(0, 3)), 2'($urandom),
              2'($urandom), ($urandom_range(0, 9) != 0), $urandom_range(0, 3) == 0, 1'($urandom));
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; req_valid = 0; wr_en = 0; req_vaddr = 0; req_kind = 0; req_priv = 0;
    req_asid = 0; single_virt = 0; urc_bound = 0;
    wr_idx = 0; wr_vpn = 0; wr_ppn = 0; wr_asid = 0; wr_size = 0; wr_prot = 0;
    wr_valid = 0; wr_shared = 0; wr_dirty = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    foreach (um[i]) um[i] = mk(0, 0, 0, 0, 0, 0, 0, 0);
    foreach (im[i]) im[i] = mk(0, 0, 0, 0, 0, 0, 0, 0);
    lf = 2'd1; urc_m = 0;
    @(negedge clk);
    chk("R4", "reset rsp_valid", 32'(rsp_valid), 0);
    chk("R11", "reset urc", 32'(urc_value), 0);
  endtask

  task automatic drive_wr(int idx, ment_t e);
    wr_en = 1; wr_idx = 6'(idx); wr_vpn = e.vpn; wr_ppn = e.ppn; wr_asid = e.asid;
    wr_size = e.sz; wr_prot = e.pr; wr_valid = e.v; wr_shared = e.sh; wr_dirty = e.d;
  endtask

  task automatic do_wr(int idx, ment_t e);
    drive_wr(idx, e);
    @(negedge clk);
    wr_en = 0;
    um[idx] = e;
  endtask

  task automatic do_req(bit [1:0] kind, bit [31:0] va, bit priv, bit [7:0] asid, bit sv, string tag);
    bit skip = sv && priv;
    int ic = 0, uc = 0, ii = 0, ui = 0, slot;
    bit use_i, multi, any, ihit;
    ment_t e;
    bit [31:0] ep = 0, low;
    bit [2:0] ee = 0;
    for (int i = 0; i < 4; i++) if (m_hit(im[i], va, asid, skip)) begin ic++; ii = i; end
    for (int i = 0; i < 64; i++) if (m_hit(um[i], va, asid, skip)) begin uc++; ui = i; end
    use_i = (kind == 0) && ic > 0;
    e = use_i ? im[ii] : um[ui];
    multi = use_i ? (ic > 1) : (uc > 1);
    any = use_i || uc > 0;
    ihit = use_i && ic == 1;
    if (multi) ee = 0;
    else if (!any) ee = (kind == 2) ? 3'd2 : 3'd1;
    else if (kind == 2) begin
      if (priv) ee = (e.pr == 0 || e.pr == 2) ? 3'd4 : (e.d ? 3'd0 : 3'd5);
      else      ee = (e.pr != 3) ? 3'd4 : (e.d ? 3'd0 : 3'd5);
    end else ee = (priv || e.pr >= 2) ? 3'd0 : 3'd3;
    if (any && !multi && ee == 0) begin
      low = (32'h1 << shamt(e.sz)) - 1;
      ep = ({3'b000, e.ppn, 10'b0} & ~low) | (va & low);
    end
    req_valid = 1; req_kind = kind; req_vaddr = va; req_priv = priv; req_asid = asid;
    single_virt = sv;
    @(negedge clk);
    req_valid = 0;
    urc_m = urc_m + 1;
    if (urc_m == 64 || (urc_bound != 0 && urc_m == int'(urc_bound))) urc_m = 0;
    if (kind == 0 && ic == 0 && uc == 1) begin
      slot = -1;
      for (int i = 3; i >= 0; i--) if (!im[i].v) slot = i;
      if (slot < 0) slot = int'(lf);
      im[slot] = um[ui];
      lf = {lf[0], lf[1] ^ lf[0]};
    end
    chk(tag, "rsp_valid (R4)", 32'(rsp_valid), 1);
    chk(tag, "paddr (R3)", rsp_paddr, ep);
    chk(tag, "exc (R5)", 32'(rsp_exc), 32'(ee));
    chk(tag, "multi (R12)", 32'(rsp_multi), 32'(multi));
    chk(tag, "itlb_hit (R9)", 32'(rsp_itlb_hit), 32'(ihit));
    chk(tag, "urc (R11)", 32'(urc_value), 32'(urc_m));
  endtask

  initial begin
    ment_t e;
    bit [31:0] va;
    void'($urandom(32'd20240611));
    do_reset();

    // R1: page size masking
    do_wr(5, mk(22'h12345 << 2, 19'h1ABCD, 8'd1, 2'd1, 2'd3, 1, 1, 1));
    do_req(2'd1, 32'h048D_1000 | 32'h0000_0ABC, 0, 8'd1, 0, "R1");
    do_req(2'd1, 32'h048D_0ABC, 0, 8'd1, 0, "R1");
    do_wr(6, mk(22'h3FF000, 19'h7F000, 8'd2, 2'd3, 2'd3, 1, 0, 1));
    do_req(2'd1, 32'hFFC7_ABCD, 1, 8'd2, 0, "R1");
    do_req(2'd1, 32'hFFB0_0000, 1, 8'd2, 0, "R1");
    do_wr(7, mk(22'h000100, 19'h00055, 8'd2, 2'd0, 2'd3, 0, 1, 1));
    do_req(2'd1, 32'h0004_0010, 1, 8'd2, 0, "R1");
    // R3: frame bits above bit 28 are dropped
    do_wr(8, mk(22'h000200, 19'h7FFFF, 8'd0, 2'd2, 2'd3, 1, 1, 1));
    do_req(2'd1, 32'h0008_1234, 0, 8'd9, 0, "R3");

    // R2: identifier matching
    do_wr(9, mk(22'h000400, 19'h00400, 8'd5, 2'd0, 2'd3, 1, 0, 1));
    do_req(2'd1, 32'h0010_0004, 0, 8'd6, 0, "R2");
    do_req(2'd1, 32'h0010_0004, 0, 8'd5, 0, "R2");
    do_req(2'd1, 32'h0010_0004, 1, 8'd6, 1, "R2");
    do_req(2'd1, 32'h0010_0004, 1, 8'd6, 0, "R2");
    do_req(2'd1, 32'h0010_0004, 0, 8'd6, 1, "R2");

    // R6 R7 R8: protection/dirty matrix
    for (int pr = 0; pr < 4; pr++)
      for (int d = 0; d < 2; d++) begin
        do_reset();
        do_wr(3, mk(22'h000800, 19'h00123, 8'd0, 2'd1, 2'(pr), 1, 1, 1'(d)));
        for (int pv = 0; pv < 2; pv++) begin
          do_req(2'd1, 32'h0020_0100, 1'(pv), 8'd0, 0, pv ? "R7" : "R8");
          do_req(2'd2, 32'h0020_0100, 1'(pv), 8'd0, 0, pv ? "R7" : "R8");
          do_req(2'd0, 32'h0020_0100, 1'(pv), 8'd0, 0, "R6");
        end
      end

    // R9 R10: refill, stale copies, replacement order
    do_reset();
    for (int i = 0; i < 7; i++) do_wr(i, mk(22'(i * 4 + 22'h1000), 19'(i + 1), 0, 2'd1, 2'd3, 1, 1, 1));
    for (int i = 0; i < 7; i++) begin
      do_req(2'd0, {22'(i * 4 + 22'h1000), 10'h0} | 32'h44, 0, 0, 0, "R10");
      do_req(2'd0, {22'(i * 4 + 22'h1000), 10'h0} | 32'h48, 0, 0, 0, "R9");
    end
    for (int i = 0; i < 7; i++) do_wr(i, mk(0, 0, 0, 0, 0, 0, 0, 0));
    for (int i = 0; i < 7; i++) do_req(2'd0, {22'(i * 4 + 22'h1000), 10'h0}, 0, 0, 0, "R9");
    do_req(2'd1, {22'h1018, 10'h0}, 0, 0, 0, "R9");

    // R12: multiple match, no refill
    do_reset();
    do_wr(10, mk(22'h002000, 19'h00011, 0, 2'd1, 2'd3, 1, 1, 1));
    do_wr(11, mk(22'h002000, 19'h00022, 0, 2'd0, 2'd3, 1, 1, 1));
    do_req(2'd1, 32'h0080_0010, 0, 0, 0, "R12");
    do_req(2'd0, 32'h0080_0010, 0, 0, 0, "R12");
    do_req(2'd0, 32'h0080_0010, 0, 0, 0, "R12");
    do_req(2'd2, 32'h0080_0800, 1, 0, 0, "R12");

    // R11: counter with bound and full wrap
    do_reset();
    urc_bound = 6'd3;
    for (int i = 0; i < 6; i++) do_req(2'd1, 32'h0, 1, 0, 0, "R11");
    urc_bound = 6'd0;
    for (int i = 0; i < 70; i++) do_req(2'd1, 32'h0, 1, 0, 0, "R11");

    // R13: same-cycle write sees old contents, next cycle sees new
    e = mk(22'h003000, 19'h00333, 0, 2'd0, 2'd3, 1, 1, 1);
    drive_wr(12, e);
    do_req(2'd1, 32'h00C0_0004, 0, 0, 0, "R13");
    wr_en = 0; um[12] = e;
    do_req(2'd1, 32'h00C0_0004, 0, 0, 0, "R13");

    // R4: idle cycle yields empty response
    @(negedge clk);
    chk("R4", "idle rsp_valid", 32'(rsp_valid), 0);
    chk("R4", "idle paddr", rsp_paddr, 0);

    // Random phase
    do_reset();
    for (int i = 0; i < 64; i++) do_wr(i, rnd_ent());
    for (int n = 0; n < 1500; n++) begin
      if ($urandom_range(0, 9) == 0) do_wr($urandom_range(0, 63), rnd_ent());
      else begin
        urc_bound = ($urandom_range(0, 7) == 0) ? 6'($urandom) : 6'd0;
        if ($urandom_range(0, 3) != 0) begin
          e = um[$urandom_range(0, 63)];
          va = {e.vpn, 10'b0} ^ ($urandom & ((32'h1 << shamt(e.sz)) - 1));
        end else va = $urandom;
        do_req(2'($urandom_range(0, 2)), va, 1'($urandom), 8'($urandom_range(0, 3)),
               1'($urandom), "R5");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule